// File: doc/BRIEF.md
# SPI Register Transaction Master for a Flow-Controlled Device

This block carries out a single register access, read or write, to a device on SPI. The device may stall each access before its data phase. A requester gives the direction, a byte count from 1 to 64 and a 24-bit register address, then pulses `start`. The block lowers chip select and shifts out a four-byte frame header. It then clocks single all-zero poll bytes until the device releases its stall, moves the data bytes and raises chip select again. Chip select stays low for the whole frame.

Write data comes in on a byte stream with valid/ready. A byte moves on a clock edge where `wdata_valid` and `wdata_ready` are both high. When no byte is offered, the master holds SCLK low between bytes and waits. It never shortens the frame. Read data goes out on a second valid/ready byte stream. A captured byte is held on `rdata` until it is taken, and no further byte is clocked until then. A slow consumer therefore stretches the frame and loses no data. `busy` and `done` report progress, and `err` reports that the device stayed stalled beyond the poll limit.

The serializer is built in. It runs SPI mode 0, sends and receives MSB first, and has a divider: each SCLK half period lasts `clk_div + 1` clock cycles.

Top module: `spireg_master`

## Requirements
- R1: Header byte 0 carries the direction in bit 7 (1 = read, 0 = write), a constant 1 in bit 6 and the byte count minus one in bits 5:0. Counts of 0 are treated as 1, and counts above 64 are treated as 64.
- R2: Header bytes 1, 2 and 3 carry address bits 23:16, 15:8 and 7:0, in that order.
- R3: After the header, the master sends 8'h00 poll bytes until a received byte has bit 0 (the last bit clocked) set. The other received bits, and the bytes received during the header, have no effect. The data phase begins with the next byte.
- R4: If `poll_limit` consecutive poll bytes all return bit 0 clear, `err` rises, no data byte is clocked, no write byte is accepted, chip select rises the cycle after `err`, and `done` pulses. A limit of 0 behaves as 1. A poll count equal to the limit with the last poll ready is a success. `err` clears at the next start.
- R5: In a write, the data bytes are the accepted write-stream bytes in order. Missing `wdata_valid` pauses the frame. Incoming MISO bits produce no read-stream output.
- R6: In a read, the master sends 8'h00 for each data byte and presents each received byte on `rdata` with `rdata_valid`. It holds that byte stable until it is accepted, and clocks the next byte only after that.
- R7: Each transaction is exactly one chip-select frame of 4 + polls + count whole bytes. SCLK is high only while chip select is low, and chip select rises only while SCLK is low.
- R8: SPI mode 0, MSB first: SCLK idles low, MOSI changes only while SCLK is low, and MISO is sampled on the rising SCLK edge.
- R9: Each SCLK high phase, and each low phase inside a byte, lasts `clk_div + 1` clock cycles.
- R10: After reset, chip select is high, SCLK is low, and `busy`, `done`, `err`, `rdata_valid` and `wdata_ready` are low. `busy` stays high from the cycle after an accepted start until `done` pulses for one cycle. A start while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transaction when idle |
| rd_en | input | 1 | 1 = register read, 0 = register write |
| len | input | 7 | Data byte count, 1 to 64 |
| addr | input | 24 | Register address |
| clk_div | input | DIV_W | SCLK half period minus one, in clock cycles |
| poll_limit | input | POLL_W | Maximum number of poll bytes |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle pulse at the end of a transaction |
| err | output | 1 | The last transaction hit the poll limit |
| wdata_valid | input | 1 | Write byte offered |
| wdata_ready | output | 1 | Master takes a write byte this cycle |
| wdata | input | 8 | Write byte |
| rdata_valid | output | 1 | Read byte held on rdata |
| rdata_ready | input | 1 | Consumer takes the read byte |
| rdata | output | 8 | Read byte |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the device |
| spi_miso | input | 1 | Serial data from the device |

## Verification
The hardest conditions to reach are a stall that lasts exactly the poll limit and a stall that lasts one poll more. These decide between a clean data phase and an aborted frame with no data. The bench device model answers each poll with a stall pattern that has every bit set except bit 0. It follows with a ready byte after a chosen number of polls, and this stall count is swept against fixed limits, including a limit of 0. Length sweeps run under stalled write and read streams, so the frame stretches between bytes. The header response has bit 0 set, to show that it does not end the wait.

// File: rtl/spireg_pkg.sv
package spireg_pkg;
  localparam int ADDR_W    = 24;
  localparam int HDR_BYTES = 4;
  localparam int MAX_LEN   = 64;
  localparam int LEN_W     = $clog2(MAX_LEN + 1);
  localparam int HIDX_W    = $clog2(HDR_BYTES);

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_HDR,
    PH_POLL,
    PH_DATA,
    PH_END
  } phase_t;

  // Frame header byte selected by position
  function automatic logic [7:0] hdr_byte(input logic rd,
                                          input logic [LEN_W-1:0] cnt,
                                          input logic [ADDR_W-1:0] a,
                                          input logic [HIDX_W-1:0] pos);
    logic [LEN_W-1:0] cm1;
    logic [7:0]       b;
    cm1 = cnt - LEN_W'(1);
    case (pos)
      HIDX_W'(0): b = {rd, 1'b1, cm1[5:0]};
      HIDX_W'(1): b = a[23:16];
      HIDX_W'(2): b = a[15:8];
      default:    b = a[7:0];
    endcase
    return b;
  endfunction
endpackage

// File: rtl/spireg_shifter.sv
module spireg_shifter #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  input  logic             go,
  input  logic [7:0]       tx,
  output logic             ready,
  output logic             byte_done,
  output logic [7:0]       rx,
  output logic             sclk,
  output logic             mosi,
  input  logic             miso
);
  logic             active;
  logic [DIV_W-1:0] cnt;
  logic [2:0]       bitn;
  logic [7:0]       tsh;
  logic [7:0]       rsh;

  assign ready = !active;
  assign mosi  = tsh[7];
  assign rx    = rsh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      cnt       <= '0;
      bitn      <= '0;
      tsh       <= '0;
      rsh       <= '0;
      sclk      <= 1'b0;
      byte_done <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      if (!active) begin
        if (go) begin
          active <= 1'b1;
          tsh    <= tx;
          cnt    <= '0;
          bitn   <= '0;
        end
      end else if (cnt == div) begin
        cnt <= '0;
        if (!sclk) begin
          sclk <= 1'b1;
          rsh  <= {rsh[6:0], miso};
        end else begin
          sclk <= 1'b0;
          if (bitn == 3'd7) begin
            active    <= 1'b0;
            byte_done <= 1'b1;
          end else begin
            bitn <= bitn + 3'd1;
            tsh  <= {tsh[6:0], 1'b0};
          end
        end
      end else begin
        cnt <= cnt + DIV_W'(1);
      end
    end
  end
endmodule

// File: rtl/spireg_seq.sv
module spireg_seq
  import spireg_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int POLL_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              rd_en,
  input  logic [LEN_W-1:0]  len,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DIV_W-1:0]  clk_div,
  input  logic [POLL_W-1:0] poll_limit,
  output logic              busy,
  output logic              done,
  output logic              err,
  input  logic              wdata_valid,
  output logic              wdata_ready,
  input  logic [7:0]        wdata,
  output logic              rdata_valid,
  input  logic              rdata_ready,
  output logic [7:0]        rdata,
  output logic              cs_n,
  output logic [DIV_W-1:0]  div_q,
  output logic              eng_go,
  output logic [7:0]        eng_tx,
  input  logic              eng_ready,
  input  logic              eng_done,
  input  logic [7:0]        eng_rx
);
  phase_t            ph;
  logic              rd_q;
  logic [LEN_W-1:0]  len_q;
  logic [ADDR_W-1:0] addr_q;
  logic [POLL_W-1:0] lim_q;
  logic [POLL_W-1:0] polls;
  logic [LEN_W-1:0]  idx;
  logic [HIDX_W-1:0] hidx;
  logic              inflight;
  logic              can_go;
  logic [LEN_W-1:0]  len_fix;
  logic              poll_out;

  assign busy     = (ph != PH_IDLE);
  assign can_go   = eng_ready && !inflight;
  assign poll_out = ({1'b0, polls} + (POLL_W + 1)'(1)) >= {1'b0, lim_q};

  always_comb begin
    if (len == '0)                     len_fix = LEN_W'(1);
    else if (len > LEN_W'(MAX_LEN))    len_fix = LEN_W'(MAX_LEN);
    else                               len_fix = len;
  end

  always_comb begin
    eng_go      = 1'b0;
    eng_tx      = 8'h00;
    wdata_ready = 1'b0;
    case (ph)
      PH_HDR: begin
        eng_go = can_go;
        eng_tx = hdr_byte(rd_q, len_q, addr_q, hidx);
      end
      PH_POLL: eng_go = can_go;
      PH_DATA: begin
        if (rd_q) begin
          eng_go = can_go && !rdata_valid;
        end else begin
          wdata_ready = can_go;
          eng_go      = can_go && wdata_valid;
          eng_tx      = wdata;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph          <= PH_IDLE;
      rd_q        <= 1'b0;
      len_q       <= LEN_W'(1);
      addr_q      <= '0;
      lim_q       <= '0;
      polls       <= '0;
      idx         <= '0;
      hidx        <= '0;
      inflight    <= 1'b0;
      div_q       <= '0;
      cs_n        <= 1'b1;
      done        <= 1'b0;
      err         <= 1'b0;
      rdata_valid <= 1'b0;
      rdata       <= '0;
    end else begin
      done <= 1'b0;
      if (eng_go)   inflight <= 1'b1;
      if (eng_done) inflight <= 1'b0;
      if (rdata_valid && rdata_ready) rdata_valid <= 1'b0;
      case (ph)
        PH_IDLE: begin
          if (start) begin
            rd_q   <= rd_en;
            len_q  <= len_fix;
            addr_q <= addr;
            lim_q  <= poll_limit;
            div_q  <= clk_div;
            polls  <= '0;
            idx    <= '0;
            hidx   <= '0;
            err    <= 1'b0;
            cs_n   <= 1'b0;
            ph     <= PH_HDR;
          end
        end
        PH_HDR: begin
          if (eng_done) begin
            if (hidx == HIDX_W'(HDR_BYTES - 1)) ph <= PH_POLL;
            hidx <= hidx + HIDX_W'(1);
          end
        end
        PH_POLL: begin
          if (eng_done) begin
            if (eng_rx[0]) begin
              ph <= PH_DATA;
            end else if (poll_out) begin
              err <= 1'b1;
              ph  <= PH_END;
            end else begin
              polls <= polls + POLL_W'(1);
            end
          end
        end
        PH_DATA: begin
          if (eng_done) begin
            if (rd_q) begin
              rdata       <= eng_rx;
              rdata_valid <= 1'b1;
            end
            if (idx == len_q - LEN_W'(1)) ph <= PH_END;
            else                          idx <= idx + LEN_W'(1);
          end
        end
        PH_END: begin
          cs_n <= 1'b1;
          done <= 1'b1;
          ph   <= PH_IDLE;
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spireg_master.sv
module spireg_master
  import spireg_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int POLL_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              rd_en,
  input  logic [LEN_W-1:0]  len,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DIV_W-1:0]  clk_div,
  input  logic [POLL_W-1:0] poll_limit,
  output logic              busy,
  output logic              done,
  output logic              err,
  input  logic              wdata_valid,
  output logic              wdata_ready,
  input  logic [7:0]        wdata,
  output logic              rdata_valid,
  input  logic              rdata_ready,
  output logic [7:0]        rdata,
  output logic              spi_cs_n,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso
);
  logic [DIV_W-1:0] div_q;
  logic             eng_go;
  logic [7:0]       eng_tx;
  logic             eng_ready;
  logic             eng_done;
  logic [7:0]       eng_rx;

  spireg_seq #(.DIV_W(DIV_W), .POLL_W(POLL_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .rd_en(rd_en), .len(len),
    .addr(addr), .clk_div(clk_div), .poll_limit(poll_limit),
    .busy(busy), .done(done), .err(err),
    .wdata_valid(wdata_valid), .wdata_ready(wdata_ready), .wdata(wdata),
    .rdata_valid(rdata_valid), .rdata_ready(rdata_ready), .rdata(rdata),
    .cs_n(spi_cs_n), .div_q(div_q),
    .eng_go(eng_go), .eng_tx(eng_tx), .eng_ready(eng_ready),
    .eng_done(eng_done), .eng_rx(eng_rx)
  );

  spireg_shifter #(.DIV_W(DIV_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .div(div_q), .go(eng_go), .tx(eng_tx),
    .ready(eng_ready), .byte_done(eng_done), .rx(eng_rx),
    .sclk(spi_sclk), .mosi(spi_mosi), .miso(spi_miso)
  );
endmodule

// File: rtl/spireg_master_chk.sv
module spireg_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       done,
  input logic       err,
  input logic       wdata_valid,
  input logic       wdata_ready,
  input logic       rdata_valid,
  input logic       rdata_ready,
  input logic [7:0] rdata,
  input logic       spi_cs_n,
  input logic       spi_sclk,
  input logic       spi_mosi
);
  // R8
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));
  // R7
  sclk_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sclk |-> !spi_cs_n);
  // R7
  cs_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n) |-> !spi_sclk);
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R10
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  // R4
  err_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |=> spi_cs_n);
  // R6
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata_valid && !rdata_ready) |=> (rdata_valid && $stable(rdata)));
  // R5
  wr_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wdata_valid && wdata_ready) |-> (!spi_cs_n && busy));
endmodule

bind spireg_master spireg_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .err(err),
  .wdata_valid(wdata_valid), .wdata_ready(wdata_ready),
  .rdata_valid(rdata_valid), .rdata_ready(rdata_ready), .rdata(rdata),
  .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi)
);

// File: tb/spireg_master_test.sv
module spireg_master_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        rd_en = 1'b0;
  logic [6:0]  len = 7'd1;
  logic [23:0] addr = '0;
  logic [7:0]  clk_div = '0;
  logic [7:0]  poll_limit = 8'd8;
  logic        busy, done, err;
  logic        wdata_valid = 1'b0;
  logic        wdata_ready;
  logic [7:0]  wdata = '0;
  logic        rdata_valid;
  logic        rdata_ready = 1'b0;
  logic [7:0]  rdata;
  logic        spi_cs_n, spi_sclk, spi_mosi;
  logic        spi_miso = 1'b0;

  always #2 clk = ~clk;

  spireg_master #(.DIV_W(8), .POLL_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .rd_en(rd_en), .len(len),
    .addr(addr), .clk_div(clk_div), .poll_limit(poll_limit),
    .busy(busy), .done(done), .err(err),
    .wdata_valid(wdata_valid), .wdata_ready(wdata_ready), .wdata(wdata),
    .rdata_valid(rdata_valid), .rdata_ready(rdata_ready), .rdata(rdata),
    .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // device model state
  logic [7:0] dev_in [0:127];
  int         dev_n = 0;
  int         dev_bit = 0;
  logic [7:0] dev_cur = '0;
  logic [7:0] dev_sh = '0;
  int         frames = 0;
  int         frame_len = 0;
  int         frame_bits = 0;
  int         stall_n = 0;
  bit         cur_rd = 1'b0;
  int         cur_len = 1;
  int         seed = 0;

  function automatic logic [7:0] rd_exp(input int i);
    return 8'(((i * 29) + seed) ^ 8'h3C);
  endfunction

  function automatic logic [7:0] dev_resp(input int k);
    if (k < 4) return 8'hFF;
    if (k < 4 + stall_n) return 8'hFE;
    if (k == 4 + stall_n) return 8'h01;
    if (cur_rd) return rd_exp(k - 5 - stall_n);
    return 8'h5A;
  endfunction

  always @(negedge spi_cs_n) begin
    dev_n    = 0;
    dev_bit  = 0;
    dev_cur  = dev_resp(0);
    spi_miso = dev_cur[7];
  end

  always @(posedge spi_sclk) begin
    if (!spi_cs_n) begin
      dev_sh = {dev_sh[6:0], spi_mosi};
      dev_bit++;
      if (dev_bit == 8) begin
        if (dev_n < 128) dev_in[dev_n] = dev_sh;
        dev_n++;
        dev_bit = 0;
      end
    end
  end

  always @(negedge spi_sclk) begin
    if (!spi_cs_n) begin
      if (dev_bit == 0) dev_cur = dev_resp(dev_n);
      spi_miso = dev_cur[7 - dev_bit];
    end
  end

  always @(posedge spi_cs_n) begin
    frames++;
    frame_len  = dev_n;
    frame_bits = dev_bit;
  end

  // stream drivers and monitors
  logic [7:0] wbuf [0:63];
  logic [7:0] rbuf [0:63];
  int  widx = 0;
  bit  w_pend = 1'b0;
  bit  wr_active = 1'b0;
  bit  bp = 1'b0;
  int  rcnt = 0;
  int  cyc = 0;
  int  hi_run = 0, hi_min = 1000, hi_max = 0;
  int  lo_run = 0, lo_min = 1000;
  int  done_cnt = 0;
  bit  busy_seen = 1'b0;

  always @(negedge clk) begin
    if (w_pend) widx++;
    wdata_valid = wr_active && (widx < cur_len) && (!bp || (cyc % 3 != 1));
    wdata       = wbuf[(widx < 64) ? widx : 63];
    w_pend      = wdata_valid && wdata_ready;
    rdata_ready = !bp || (cyc % 4 != 0);
    if (rdata_valid && rdata_ready) begin
      if (rcnt < 64) rbuf[rcnt] = rdata;
      rcnt++;
    end
    if (spi_sclk) hi_run++;
    else begin
      if (hi_run > 0) begin
        if (hi_run < hi_min) hi_min = hi_run;
        if (hi_run > hi_max) hi_max = hi_run;
      end
      hi_run = 0;
    end
    if (!spi_cs_n && !spi_sclk) lo_run++;
    else begin
      if (spi_sclk && lo_run > 0 && lo_run < lo_min) lo_min = lo_run;
      lo_run = 0;
    end
    if (done) done_cnt++;
    if (busy) busy_seen = 1'b1;
    cyc++;
  end

  task automatic run(input bit rd, input int n, input logic [23:0] a,
                     input int stall, input int div, input int lim,
                     input bit bpv, input bit poke);
    int  frames0;
    int  t;
    int  eff_lim;
    bit  exp_err;
    int  polls;
    int  cnt;
    @(negedge clk);
    stall_n = stall;
    cur_rd  = rd;
    cur_len = n;
    seed    = n * 7 + (rd ? 3 : 0);
    for (int i = 0; i < 64; i++) wbuf[i] = 8'((i * 53) + n + 7);
    widx = 0; w_pend = 1'b0; rcnt = 0;
    hi_min = 1000; hi_max = 0; lo_min = 1000;
    done_cnt = 0; busy_seen = 1'b0; bp = bpv;
    wr_active = !rd;
    frames0 = frames;
    rd_en = rd; len = 7'(n); addr = a; clk_div = 8'(div);
    poll_limit = 8'(lim); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    t = 0;
    while (!done && t < 50000) begin
      @(negedge clk);
      t++;
      if (poke && t == 20) begin start = 1'b1; addr = ~a; rd_en = !rd; end
      else start = 1'b0;
    end
    start = 1'b0;
    repeat (12) @(negedge clk);
    wr_active = 1'b0;

    eff_lim = (lim == 0) ? 1 : lim;
    exp_err = (stall >= eff_lim);
    polls   = exp_err ? eff_lim : stall + 1;
    cnt     = exp_err ? 0 : n;

    chk(t < 50000, "R10", "done reached", t, 0);
    chk(done_cnt == 1, "R10", "done pulse count", done_cnt, 1);
    chk(busy_seen, "R10", "busy seen", busy_seen, 1);
    chk(!busy, "R10", "idle after done", busy, 0);
    chk(frames - frames0 == 1, "R7", "frame count", frames - frames0, 1);
    chk(frame_bits == 0, "R7", "whole bytes", frame_bits, 0);
    chk(frame_len == 4 + polls + cnt, "R7", "frame length", frame_len, 4 + polls + cnt);
    chk(dev_in[0] == {rd, 1'b1, 6'(n - 1)}, "R1", "header byte 0", dev_in[0], {rd, 1'b1, 6'(n - 1)});
    chk(dev_in[1] == a[23:16], "R2", "addr high", dev_in[1], a[23:16]);
    chk(dev_in[2] == a[15:8], "R2", "addr mid", dev_in[2], a[15:8]);
    chk(dev_in[3] == a[7:0], "R2", "addr low", dev_in[3], a[7:0]);
    for (int p = 0; p < polls; p++)
      chk(dev_in[4 + p] == 8'h00, "R3", "poll byte zero", dev_in[4 + p], 0);
    chk(err == exp_err, "R4", "err flag", err, exp_err);
    if (exp_err) begin
      chk(widx == 0, "R4", "no write byte taken", widx, 0);
      chk(rcnt == 0, "R4", "no read byte given", rcnt, 0);
    end else if (!rd) begin
      chk(widx == n, "R5", "write bytes taken", widx, n);
      chk(rcnt == 0, "R5", "no read output on write", rcnt, 0);
      for (int i = 0; i < n; i++)
        chk(dev_in[4 + polls + i] == wbuf[i], "R5", "write data", dev_in[4 + polls + i], wbuf[i]);
    end else begin
      chk(rcnt == n, "R6", "read byte count", rcnt, n);
      for (int i = 0; i < n; i++) begin
        chk(rbuf[i] == rd_exp(i), "R6", "read data", rbuf[i], rd_exp(i));
        chk(dev_in[4 + polls + i] == 8'h00, "R6", "read dummy byte", dev_in[4 + polls + i], 0);
      end
    end
    chk(hi_min == div + 1 && hi_max == div + 1, "R9", "sclk high width", hi_max, div + 1);
    chk(lo_min == div + 1, "R9", "sclk low width", lo_min, div + 1);
    chk(!spi_sclk && spi_cs_n, "R8", "idle bus levels", {spi_sclk, spi_cs_n}, 1);
  endtask

  initial begin
    #800000;
    errors++;
    checks++;
    $display("FAIL R10 watchdog: actual hung expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(spi_cs_n == 1'b1, "R10", "reset cs_n", spi_cs_n, 1);
    chk(spi_sclk == 1'b0, "R10", "reset sclk", spi_sclk, 0);
    chk(!busy && !done && !err, "R10", "reset flags", {busy, done, err}, 0);
    chk(!rdata_valid && !wdata_ready, "R10", "reset streams", {rdata_valid, wdata_ready}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int r = 0; r < 2; r++)
      for (int n = 1; n <= 64; n++)
        run(r[0], n, 24'(n * 24'h010203) ^ (r[0] ? 24'hA50000 : 24'h0),
            (n + r) % 4, (n <= 6) ? (n % 3) : 0, 8, (n % 5 == 0), 1'b0);

    run(1'b1, 4, 24'hFFFFFF, 0, 0, 8, 1'b0, 1'b0);
    run(1'b0, 4, 24'h000000, 1, 1, 8, 1'b0, 1'b0);
    // poll limit boundaries
    run(1'b0, 3, 24'h123456, 3, 0, 3, 1'b0, 1'b0);
    run(1'b1, 3, 24'h654321, 2, 0, 3, 1'b0, 1'b0);
    run(1'b1, 2, 24'h00F00D, 3, 0, 3, 1'b0, 1'b0);
    run(1'b0, 2, 24'h0BEEF0, 1, 0, 0, 1'b0, 1'b0);
    run(1'b1, 2, 24'h0C0FFE, 0, 0, 0, 1'b0, 1'b0);
    // start while busy is ignored
    run(1'b0, 6, 24'h5AA5C3, 1, 0, 8, 1'b1, 1'b1);
    run(1'b1, 6, 24'h3C5AA5, 2, 2, 8, 1'b1, 1'b1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule